// File: doc/BRIEF.md
# Phase-Accumulator Clock Synthesizer With Edge-Error Output

This block builds a square-wave clock from a master clock by numerical control. A phase register grows by a programmable step on every master cycle and wraps at a programmable modulus. That modulus can be any value from 2 up to two to the power of the register width, so it is not limited to powers of two. The synthesized clock is the half-range flag of the phase. It is high while the phase lies in the lower half of the modulus, so each rising edge falls on a wrap. For a power-of-two modulus this flag is the inverted top bit of the phase. No waveform lookup and no converter follow the register, so the output edges can only sit on master-clock edges.

Each rising edge also produces a timing report. The report gives how far that edge lags the ideal edge. Ideal edges fall every modulus/step master cycles, counted from the last configuration write. The lag is the residue left in the phase at the wrap, divided by the step. It appears as a signed fixed-point number, in master-clock periods, on a streaming output with a one-cycle valid strobe. A jitter analyser downstream can use this sequence in the time domain without seeing the phase register itself.

Software or a control FSM writes the step and the modulus together through a single write strobe. A write restarts the phase at zero. Legal settings have a nonzero step of at most half the modulus (rounded down).

Top module: `nco_clk_synth`

## Requirements
- R1: While reset is low, and after reset until the first configuration write, `clk_out` is 1, `err_valid` is 0 and `err_phase` is 0 (the reset step is zero, so the phase does not move).
- R2: In each cycle the phase P becomes (P + step) mod modulus. From the cycle after each update, `clk_out` is 1 exactly when P < floor(modulus/2).
- R3: `err_valid` is 1 for exactly one cycle in each cycle whose update wrapped. That is the same cycle in which `clk_out` rises, and it is never high in two cycles in a row.
- R4: When `err_valid` is 1, `err_phase` equals floor(r * 2^FRAC_W / step), where r is the phase just after the wrap. It is two's complement with FRAC_W fraction bits and a sign bit on top, and it always lies in [0, 1). The output edge therefore never lags its ideal position by a full master period.
- R5: When the step divides a power-of-two modulus (for example 32 of 128), every reported error is exactly 0 and the edges are evenly spaced.
- R6: When the step divides a modulus that is not a power of two (for example 40 of 120), every reported error is exactly 0.
- R7: With step 55 and modulus 128, the 55th edge after a write lands exactly on master cycle 128 with error 0. Error n+55 equals error n for every n.
- R8: A write (`cfg_we` = 1) loads the step and modulus, and in the next cycle the phase is 0. `clk_out` is then 1 and `err_valid` is 0, and edge timing restarts from that cycle, even in the middle of a run.
- R9: Over C cycles after a write, exactly floor(C * step / modulus) edges are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Load step and modulus, restart the phase |
| cfg_inc | input | ACC_W | Phase step per master cycle |
| cfg_mod | input | ACC_W+1 | Wrap modulus, 2 to 2^ACC_W |
| clk_out | output | 1 | Synthesized clock, high in the lower half of the phase range |
| err_valid | output | 1 | One-cycle strobe on each rising edge of `clk_out` |
| err_phase | output | FRAC_W+1 | Signed lag of the edge behind its ideal position, FRAC_W fraction bits |

## Verification
The bench builds the block with its defaults, an 8-bit phase register and 8 fraction bits. With these widths a modulus of 256 (the largest the register holds) sits next to 128, odd moduli such as 7, and the divisible non-power-of-two case 120/40. Eight fraction bits give each reported error an exact integer to match. The full 55-of-128 cycle can be run twice in a few hundred cycles, so the repetition after 55 edges is compared edge by edge. The narrow widths also let a step of 1 against a modulus of 2 drive the clock at half the master rate, which is the densest wrap pattern the block allows.

// File: rtl/nco_pkg.sv
// Package for the clock synthesizer: default widths shared by the
// design, the checker and anyone who instantiates the block.
package nco_pkg;

    // Width of the phase register (modulus may reach 2**NCO_ACC_W)
    localparam int unsigned NCO_ACC_W  = 8;
    // Fraction bits of the reported edge error
    localparam int unsigned NCO_FRAC_W = 8;

endpackage

// File: rtl/nco_phase_core.sv
// Phase register with programmable step and modulus.
// Holds the configuration, advances the phase by the step every cycle
// and wraps by subtracting the modulus. Gives the next phase, the wrap
// flag and the next half-range flag to the output stage.
// Assumes 0 < step <= modulus/2 and 2 <= modulus <= 2**ACC_W.
module nco_phase_core
    import nco_pkg::*;
#(
    parameter int unsigned ACC_W = NCO_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [ACC_W-1:0] cfg_inc,
    input  logic [ACC_W:0]   cfg_mod,
    output logic [ACC_W-1:0] inc_q,
    output logic [ACC_W-1:0] acc_nxt,
    output logic             wrap_nxt,
    output logic             low_half_nxt
);

    localparam logic [ACC_W:0] RST_MOD = {1'b1, {ACC_W{1'b0}}};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   mod_q;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   half;

    // Next phase: add the step, take the modulus off once on overflow
    always_comb begin
        sum          = {1'b0, acc_q} + {1'b0, inc_q};
        wrap_nxt     = (sum >= mod_q);
        acc_nxt      = wrap_nxt ? ACC_W'(sum - mod_q) : ACC_W'(sum);
        half         = mod_q >> 1;
        low_half_nxt = ({1'b0, acc_nxt} < half);
    end

    // Configuration and phase registers; a write restarts the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
            mod_q <= RST_MOD;
            acc_q <= '0;
        end else if (cfg_we) begin
            inc_q <= cfg_inc;
            mod_q <= cfg_mod;
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/nco_frac_div.sv
// Fraction divider for the edge error.
// Computes floor(rem_in * 2**FRAC_W / den) as FRAC_W quotient bits with
// a chain of restoring stages, one quotient bit per stage, with no
// registers. Assumes rem_in < den, so the integer part is zero.
module nco_frac_div
    import nco_pkg::*;
#(
    parameter int unsigned ACC_W  = NCO_ACC_W,
    parameter int unsigned FRAC_W = NCO_FRAC_W
) (
    input  logic [ACC_W-1:0]  rem_in,
    input  logic [ACC_W-1:0]  den,
    output logic [FRAC_W-1:0] quo
);

    logic [ACC_W-1:0] rem [FRAC_W];

    assign rem[0] = rem_in;

    // One restoring stage per quotient bit, most significant first
    for (genvar i = 0; i < FRAC_W; i++) begin : g_stage
        logic [ACC_W:0] trial;
        logic           take;
        assign trial = {rem[i], 1'b0};
        assign take  = (trial >= {1'b0, den});
        assign quo[FRAC_W-1-i] = take;
        if (i < FRAC_W - 1) begin : g_next
            assign rem[i+1] = take ? ACC_W'(trial - {1'b0, den})
                                   : trial[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/nco_clk_synth.sv
// Clock synthesizer top.
// The phase core gives the next phase and wrap flag, the divider turns
// the wrap residue into a lag in master periods, and this level
// registers the clock, the strobe and the error so all three change in
// the same cycle. Assumes legal settings as described for the core.
module nco_clk_synth
    import nco_pkg::*;
#(
    parameter int unsigned ACC_W  = NCO_ACC_W,
    parameter int unsigned FRAC_W = NCO_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ACC_W-1:0]         cfg_inc,
    input  logic [ACC_W:0]           cfg_mod,
    output logic                     clk_out,
    output logic                     err_valid,
    output logic signed [FRAC_W:0]   err_phase
);

    logic [ACC_W-1:0]  inc_q;
    logic [ACC_W-1:0]  acc_nxt;
    logic              wrap_nxt;
    logic              low_half_nxt;
    logic [FRAC_W-1:0] frac_nxt;

    nco_phase_core #(
        .ACC_W        (ACC_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_inc      (cfg_inc),
        .cfg_mod      (cfg_mod),
        .inc_q        (inc_q),
        .acc_nxt      (acc_nxt),
        .wrap_nxt     (wrap_nxt),
        .low_half_nxt (low_half_nxt)
    );

    nco_frac_div #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .rem_in (acc_nxt),
        .den    (inc_q),
        .quo    (frac_nxt)
    );

    // Output stage: clock flag, edge strobe and held error value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_out   <= 1'b1;
            err_valid <= 1'b0;
            err_phase <= '0;
        end else if (cfg_we) begin
            clk_out   <= 1'b1;
            err_valid <= 1'b0;
            err_phase <= '0;
        end else begin
            clk_out   <= low_half_nxt;
            err_valid <= wrap_nxt;
            if (wrap_nxt) begin
                err_phase <= $signed({1'b0, frac_nxt});
            end
        end
    end

endmodule

// File: rtl/nco_clk_synth_chk.sv
// Checker for the clock synthesizer, bound to every instance of the top.
// Looks only at the top's ports; assumes the legal settings stated for
// the block.
module nco_clk_synth_chk #(
    parameter int unsigned FRAC_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   clk_out,
    input logic                   err_valid,
    input logic signed [FRAC_W:0] err_phase
);

    AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (clk_out && !$past(clk_out)));                  // R3

    AST_RISE_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_out) && !$past(cfg_we)) |-> err_valid);            // R3

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);                                    // R3

    AST_ERR_BELOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !err_phase[FRAC_W]);                            // R4

    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (clk_out && !err_valid));                          // R8

endmodule

bind nco_clk_synth nco_clk_synth_chk #(
    .FRAC_W    (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .clk_out   (clk_out),
    .err_valid (err_valid),
    .err_phase (err_phase)
);

// File: tb/tb_nco_clk_synth.sv
// Bench for the clock synthesizer: a vector table walked by one loop,
// then directed tests for reset and mid-run configuration writes.
module tb_nco_clk_synth;

    localparam int ACC_W  = 8;
    localparam int FRAC_W = 8;
    localparam int ONE    = 1 << FRAC_W;

    // step, modulus, cycles to run, expected edge count
    localparam int NVEC = 6;
    localparam int VEC [NVEC][4] = '{
        '{32, 128,  64,  16},
        '{55, 128, 256, 110},
        '{40, 120,  90,  30},
        '{ 3,   7,  70,  30},
        '{ 1,   2,  20,  10},
        '{100, 256, 256, 100}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cfg_we = 1'b0;
    logic [ACC_W-1:0]       cfg_inc = '0;
    logic [ACC_W:0]         cfg_mod = '0;
    logic                   clk_out;
    logic                   err_valid;
    logic signed [FRAC_W:0] err_phase;

    int total = 0;
    int bad = 0;
    int acc_m, k_m, m_m, edges, maxe, lastk;
    int seq [0:127];
    bit finished = 0;

    always #10 clk = ~clk;

    nco_clk_synth #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_inc   (cfg_inc),
        .cfg_mod   (cfg_mod),
        .clk_out   (clk_out),
        .err_valid (err_valid),
        .err_phase (err_phase)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Write step and modulus, then check the restart state (R8)
    task automatic load(input int k, input int m);
        @(negedge clk);
        cfg_inc = k[ACC_W-1:0];
        cfg_mod = m[ACC_W:0];
        cfg_we  = 1'b1;
        @(negedge clk);
        cfg_we  = 1'b0;
        chk(clk_out == 1'b1, "R8 clk_out high after write", int'(clk_out), 1);
        chk(err_valid == 1'b0, "R8 no strobe after write", int'(err_valid), 0);
        acc_m = 0; k_m = k; m_m = m; edges = 0; maxe = 0;
    endtask

    // Advance the reference phase one cycle and compare the outputs
    task automatic step(output bit v, output int e);
        int s;
        @(negedge clk);
        s     = acc_m + k_m;
        v     = (s >= m_m);
        acc_m = v ? s - m_m : s;
        e     = (acc_m * ONE) / k_m;
        chk(clk_out == (acc_m < m_m / 2), "R2 clk_out level", int'(clk_out),
            int'(acc_m < m_m / 2));
        chk(err_valid == v, "R3 strobe on wrap", int'(err_valid), int'(v));
        if (v) begin
            chk(int'(err_phase) == e, "R4 error value", int'(err_phase), e);
            chk(err_phase >= 0 && int'(err_phase) < ONE, "R4 error in [0,1)",
                int'(err_phase), e);
            if (e > maxe) maxe = e;
            lastk = e;
            edges++;
        end
    endtask

    initial begin
        bit v;
        int e;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(clk_out == 1'b1, "R1 clk_out in reset", int'(clk_out), 1);
        chk(err_valid == 1'b0, "R1 strobe in reset", int'(err_valid), 0);
        chk(err_phase == 0, "R1 error in reset", int'(err_phase), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(clk_out == 1'b1 && err_valid == 1'b0, "R1 idle after reset",
                int'({clk_out, err_valid}), 2);
        end

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            load(VEC[i][0], VEC[i][1]);
            for (int c = 0; c < VEC[i][2]; c++) begin
                step(v, e);
                if (i == 1 && v && edges <= 128) seq[edges-1] = e;
                if (i == 1 && c == 127) begin
                    chk(edges == 55, "R7 edges in 128 cycles", edges, 55);
                    chk(v && e == 0, "R7 edge 55 on cycle 128 with zero error",
                        int'(err_phase), 0);
                end
            end
            chk(edges == VEC[i][3], "R9 edge count", edges, VEC[i][3]);
            if (i == 0) chk(maxe == 0, "R5 zero error, power-of-two modulus", maxe, 0);
            if (i == 2) chk(maxe == 0, "R6 zero error, modulus 120", maxe, 0);
            if (i == 1) begin
                for (int n = 0; n < 55; n++)
                    chk(seq[n] == seq[n+55], "R7 repeat after 55 edges",
                        seq[n+55], seq[n]);
            end
        end

        // R8: mid-run rewrite of the same setting restarts timing
        load(3, 7);
        repeat (5) step(v, e);
        load(3, 7);
        repeat (14) step(v, e);
        chk(edges == 6, "R8 edges after restart", edges, 6);

        // R8: mid-run switch to a different setting
        load(5, 11);
        repeat (4) step(v, e);
        load(9, 20);
        repeat (40) step(v, e);
        chk(edges == 18, "R9 edges after switch", edges, 18);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule